// File: doc/BRIEF.md
# Field-Aware Pixel Request Window Generator

This block sits on the pixel clock next to a video input path. It watches the horizontal and vertical sync pulses and drives a request strobe that tells an upstream source when to deliver pixels. The strobe is active only on lines inside a vertical window. The window's first line depends on the parity of the current field and on whether lookup-table data is fetched at the start of the field. Inside each active line, the strobe opens a programmable number of clocks after the horizontal sync and stays open for a programmable pixel count.

Five 10-bit settings are loaded through a byte-wide write port: horizontal offset, pixel count, odd-field line offset, even-field line offset and line count. Each setting has its own low-byte register. The upper two bits of four of the settings share one packed register. Writes land in shadow storage and are copied to the working set at the next vertical sync. The field parity and the table-fetch flag are captured at that same sync, so a field never mixes settings.

Top module: `req_window_gen`

## Requirements
- R1: Byte writes (wr_en high) load shadow settings by wr_addr: 0 horizontal offset [7:0], 1 pixel count [7:0], 2 odd offset [7:0], 3 even offset [7:0], 4 packed upper bits (data[7:6] even offset [9:8], [5:4] odd offset [9:8], [3:2] pixel count [9:8], [1:0] horizontal offset [9:8]), 5 line count [7:0], 6 line count [9:8] in data[1:0]; addresses 7 is ignored.
- R2: The working settings take the shadow values only on a clock where vsync is high. A write on that same clock waits for the following vsync.
- R3: field_odd (1 = odd field) and lut_req are sampled only when vsync is high. Changes between vsync pulses have no effect.
- R4: line_cnt becomes 0 on the clock after vsync is high. Otherwise it increments on the clock after each hsync and saturates at 1023. vsync has priority over hsync.
- R5: line_active is high while line_cnt is inside the window starting at S, where S is the selected offset plus 2 when lut_req was 0, and S is the selected offset itself when lut_req was 1.
- R6: The window spans N = lines + even offset − odd offset lines (signed). If N is zero or below, line_active stays low for the whole field.
- R7: The horizontal position is 0 on the clock after hsync and increments each clock, saturating at 2047. cbo is high exactly when line_active is high and the position lies in [hoff, hoff+pix).
- R8: An hsync that arrives before the pulse ends restarts the position, which cuts the pulse short.
- R9: A pixel count of 0 gives no cbo.
- R10: After reset the outputs are 0 and every setting is 0, so no strobe appears before settings are committed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hsync | input | 1 | One-clock horizontal sync pulse |
| vsync | input | 1 | One-clock vertical sync pulse |
| field_odd | input | 1 | Field parity, 1 = odd |
| lut_req | input | 1 | Table data is fetched at the start of the field |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 8 | Register write data |
| cbo | output | 1 | Pixel request strobe |
| line_active | output | 1 | Current line lies in the request window |
| line_cnt | output | 10 | Lines since the last vertical sync |

## Verification
The bench aims at the start line for each combination of field parity and table fetch. A design that picks the wrong offset or drops the two-line gap opens the window a line early or late. It also programs an odd offset larger than the even offset so that the corrected line count goes negative. An unsigned subtraction there would open an almost endless window. Other cases are a write in the middle of a field and a parity change between syncs, either of which would bend the current field if taken at once. The remaining cases are a line period shorter than the strobe, where a counter that is not restarted keeps the strobe high, and long runs that drive both counters into saturation, where a counter that wraps would reopen the window.

// File: rtl/rwg_pkg.sv
package rwg_pkg;
  localparam int unsigned FW = 10;
  localparam int unsigned AW = 3;
  localparam int unsigned LUT_GAP = 2;

  localparam logic [AW-1:0] A_HOFF   = 3'd0;
  localparam logic [AW-1:0] A_PIX    = 3'd1;
  localparam logic [AW-1:0] A_VODD   = 3'd2;
  localparam logic [AW-1:0] A_VEVEN  = 3'd3;
  localparam logic [AW-1:0] A_MSB    = 3'd4;
  localparam logic [AW-1:0] A_LINES  = 3'd5;
  localparam logic [AW-1:0] A_LINESH = 3'd6;

  typedef struct packed {
    logic [FW-1:0] hoff;
    logic [FW-1:0] pix;
    logic [FW-1:0] voff_odd;
    logic [FW-1:0] voff_even;
    logic [FW-1:0] lines;
  } cfg_t;
endpackage

// File: rtl/rwg_cfg.sv
module rwg_cfg
  import rwg_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [7:0]    wr_data,
  input  logic          vsync,
  input  logic          field_odd,
  input  logic          lut_req,
  output cfg_t          act,
  output logic          act_odd,
  output logic          act_lut
);
  cfg_t shd_q, shd_d;
  cfg_t act_q, act_d;
  logic odd_q, odd_d, lut_q, lut_d;

  always_comb begin
    shd_d = shd_q;
    if (wr_en) begin
      case (wr_addr)
        A_HOFF:   shd_d.hoff[7:0]      = wr_data;
        A_PIX:    shd_d.pix[7:0]       = wr_data;
        A_VODD:   shd_d.voff_odd[7:0]  = wr_data;
        A_VEVEN:  shd_d.voff_even[7:0] = wr_data;
        A_MSB: begin
          shd_d.voff_even[FW-1:8] = wr_data[7:6];
          shd_d.voff_odd[FW-1:8]  = wr_data[5:4];
          shd_d.pix[FW-1:8]       = wr_data[3:2];
          shd_d.hoff[FW-1:8]      = wr_data[1:0];
        end
        A_LINES:  shd_d.lines[7:0]     = wr_data;
        A_LINESH: shd_d.lines[FW-1:8]  = wr_data[1:0];
        default:  shd_d = shd_q;
      endcase
    end
  end

  always_comb begin
    act_d = act_q;
    odd_d = odd_q;
    lut_d = lut_q;
    if (vsync) begin
      act_d = shd_q;
      odd_d = field_odd;
      lut_d = lut_req;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shd_q <= '0;
      act_q <= '0;
      odd_q <= 1'b0;
      lut_q <= 1'b0;
    end else begin
      shd_q <= shd_d;
      act_q <= act_d;
      odd_q <= odd_d;
      lut_q <= lut_d;
    end
  end

  assign act     = act_q;
  assign act_odd = odd_q;
  assign act_lut = lut_q;

  // R2
  act_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !vsync |=> $stable(act_q));
  // R3
  parity_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !vsync |=> ($stable(odd_q) && $stable(lut_q)));
endmodule

// File: rtl/rwg_vert.sv
module rwg_vert
  import rwg_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hsync,
  input  logic          vsync,
  input  cfg_t          act,
  input  logic          act_odd,
  input  logic          act_lut,
  output logic          line_active,
  output logic [FW-1:0] line_cnt
);
  localparam int unsigned SW = FW + 3;
  localparam logic [FW-1:0] LMAX = '1;

  logic [FW-1:0] line_q, line_d;
  logic [FW-1:0] voff_sel;
  logic signed [SW-1:0] start_s, span_s, end_s, line_s;
  logic span_pos;

  always_comb begin
    line_d = line_q;
    if (vsync)
      line_d = '0;
    else if (hsync && line_q != LMAX)
      line_d = line_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) line_q <= '0;
    else        line_q <= line_d;
  end

  always_comb begin
    voff_sel = act_odd ? act.voff_odd : act.voff_even;
    start_s  = SW'(voff_sel) + (act_lut ? SW'(0) : SW'(LUT_GAP));
    span_s   = SW'(act.lines) + SW'(act.voff_even) - SW'(act.voff_odd);
    end_s    = start_s + span_s;
    line_s   = SW'(line_q);
    span_pos = !span_s[SW-1] && (span_s != '0);
    line_active = span_pos && (line_s >= start_s) && (line_s < end_s);
  end

  assign line_cnt = line_q;

  // R4
  line_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vsync |=> (line_cnt == '0));
  // R4
  line_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hsync && !vsync && line_cnt != LMAX) |=> (line_cnt == $past(line_cnt) + 1'b1));
  // R6
  empty_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !span_pos |-> !line_active);
endmodule

// File: rtl/rwg_horz.sv
module rwg_horz
  import rwg_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hsync,
  input  logic          line_active,
  input  logic [FW-1:0] hoff,
  input  logic [FW-1:0] pix,
  output logic          cbo
);
  localparam int unsigned HW = FW + 1;
  localparam logic [HW-1:0] HMAX = '1;

  logic [HW-1:0] hcnt_q, hcnt_d;
  logic [HW-1:0] open_at, close_at;

  always_comb begin
    hcnt_d = hcnt_q;
    if (hsync)
      hcnt_d = '0;
    else if (hcnt_q != HMAX)
      hcnt_d = hcnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hcnt_q <= '0;
    else        hcnt_q <= hcnt_d;
  end

  always_comb begin
    open_at  = {1'b0, hoff};
    close_at = {1'b0, hoff} + {1'b0, pix};
    cbo = line_active && (hcnt_q >= open_at) && (hcnt_q < close_at);
  end

  // R7
  cbo_in_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cbo |-> line_active);
  // R9
  zero_pix_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pix == '0) |-> !cbo);
  // R8
  restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hsync |=> (hcnt_q == '0));
endmodule

// File: rtl/req_window_gen.sv
module req_window_gen
  import rwg_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hsync,
  input  logic          vsync,
  input  logic          field_odd,
  input  logic          lut_req,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [7:0]    wr_data,
  output logic          cbo,
  output logic          line_active,
  output logic [FW-1:0] line_cnt
);
  cfg_t act;
  logic act_odd, act_lut;

  rwg_cfg i_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .vsync(vsync), .field_odd(field_odd),
    .lut_req(lut_req), .act(act), .act_odd(act_odd), .act_lut(act_lut)
  );

  rwg_vert i_vert (
    .clk(clk), .rst_n(rst_n), .hsync(hsync), .vsync(vsync), .act(act),
    .act_odd(act_odd), .act_lut(act_lut), .line_active(line_active),
    .line_cnt(line_cnt)
  );

  rwg_horz i_horz (
    .clk(clk), .rst_n(rst_n), .hsync(hsync), .line_active(line_active),
    .hoff(act.hoff), .pix(act.pix), .cbo(cbo)
  );
endmodule

// File: tb/test_req_window_gen.sv
module test_req_window_gen;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hsync = 1'b0, vsync = 1'b0, field_odd = 1'b0, lut_req = 1'b0, wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic cbo, line_active;
  logic [9:0] line_cnt;

  int checks = 0, fails = 0, cycles = 0;
  bit checking = 0;
  string cur_req = "R10";

  // reference model state
  int s_hoff, s_pix, s_vo, s_ve, s_ln;
  int a_hoff, a_pix, a_vo, a_ve, a_ln, a_odd, a_lut;
  int m_line, m_hpos;

  req_window_gen i_req_window_gen (
    .clk(clk), .rst_n(rst_n), .hsync(hsync), .vsync(vsync),
    .field_odd(field_odd), .lut_req(lut_req), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .cbo(cbo),
    .line_active(line_active), .line_cnt(line_cnt)
  );

  always #4 clk = ~clk;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_hoff = 0; s_pix = 0; s_vo = 0; s_ve = 0; s_ln = 0;
      a_hoff = 0; a_pix = 0; a_vo = 0; a_ve = 0; a_ln = 0; a_odd = 0; a_lut = 0;
      m_line = 0; m_hpos = 0;
    end else begin
      if (vsync) begin
        a_hoff = s_hoff; a_pix = s_pix; a_vo = s_vo; a_ve = s_ve; a_ln = s_ln;
        a_odd = field_odd; a_lut = lut_req;
      end
      if (wr_en) begin
        case (wr_addr)
          3'd0: s_hoff = (s_hoff & 768) | wr_data;
          3'd1: s_pix  = (s_pix & 768) | wr_data;
          3'd2: s_vo   = (s_vo & 768) | wr_data;
          3'd3: s_ve   = (s_ve & 768) | wr_data;
          3'd4: begin
            s_ve   = (s_ve & 255)   | (((wr_data >> 6) & 3) << 8);
            s_vo   = (s_vo & 255)   | (((wr_data >> 4) & 3) << 8);
            s_pix  = (s_pix & 255)  | (((wr_data >> 2) & 3) << 8);
            s_hoff = (s_hoff & 255) | ((wr_data & 3) << 8);
          end
          3'd5: s_ln = (s_ln & 768) | wr_data;
          3'd6: s_ln = (s_ln & 255) | ((wr_data & 3) << 8);
          default: ;
        endcase
      end
      if (vsync) m_line = 0;
      else if (hsync && m_line < 1023) m_line = m_line + 1;
      if (hsync) m_hpos = 0;
      else if (m_hpos < 2047) m_hpos = m_hpos + 1;
    end
  end

  function automatic bit exp_active();
    int st, n;
    st = (a_odd ? a_vo : a_ve) + (a_lut ? 0 : 2);
    n = a_ln + a_ve - a_vo;
    return (n > 0) && (m_line >= st) && (m_line < st + n);
  endfunction

  always @(negedge clk) begin
    if (rst_n && checking) begin
      bit ea, ec;
      ea = exp_active();
      ec = ea && (m_hpos >= a_hoff) && (m_hpos < a_hoff + a_pix);
      checks++;
      if (line_cnt !== 10'(m_line) || line_active !== ea || cbo !== ec) begin
        fails++;
        $display("FAIL %s (line R4/window R5/strobe R7) t=%0t: actual line=%0d act=%0b cbo=%0b expected line=%0d act=%0b cbo=%0b",
                 cur_req, $time, line_cnt, line_active, cbo, m_line, ea, ec);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles == 150000) begin
      fails++;
      $display("FAIL R10 watchdog expired: actual %0d cycles expected completion", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic wr(input int a, input int d);
    wr_en = 1'b1; wr_addr = 3'(a); wr_data = 8'(d);
    tick();
    wr_en = 1'b0;
  endtask

  task automatic setup(input int hoff, input int pix, input int vo, input int ve, input int ln);
    wr(0, hoff & 255); wr(1, pix & 255); wr(2, vo & 255); wr(3, ve & 255);
    wr(4, ((ve >> 8) << 6) | ((vo >> 8) << 4) | ((pix >> 8) << 2) | (hoff >> 8));
    wr(5, ln & 255); wr(6, ln >> 8);
  endtask

  // R3: parity and table flag flip after the sync and must be ignored
  task automatic run_field(input bit odd, input bit lut, input int nl, input int hp);
    field_odd = odd; lut_req = lut; vsync = 1'b1;
    tick();
    vsync = 1'b0; field_odd = ~odd; lut_req = ~lut;
    for (int l = 0; l < nl; l++) begin
      hsync = 1'b1;
      tick();
      hsync = 1'b0;
      for (int c = 1; c < hp; c++) tick();
    end
  endtask

  initial begin
    #20;
    checks++;
    if (cbo !== 1'b0 || line_active !== 1'b0 || line_cnt !== '0) begin
      fails++;
      $display("FAIL R10 reset: actual cbo=%0b act=%0b line=%0d expected 0 0 0", cbo, line_active, line_cnt);
    end
    @(negedge clk); rst_n = 1'b1;
    tick();
    checking = 1;
    cur_req = "R10"; run_field(1, 0, 10, 30);
    cur_req = "R1"; setup(5, 10, 2, 3, 4);
    cur_req = "R2"; run_field(1, 0, 12, 30);   // settings only now take effect
    cur_req = "R5"; run_field(1, 0, 12, 30);   // odd, gap of two
    cur_req = "R5"; run_field(0, 1, 12, 30);   // even, no gap
    cur_req = "R3"; run_field(0, 0, 12, 30);
    cur_req = "R2"; wr(0, 1); wr(1, 3);        // mid-field write, prior settings hold
    run_field(1, 1, 1, 30);
    vsync = 1'b0; for (int l = 0; l < 10; l++) begin hsync = 1'b1; tick(); hsync = 1'b0; for (int c = 1; c < 30; c++) tick(); end
    run_field(1, 1, 10, 30);
    cur_req = "R6"; setup(4, 6, 6, 1, 3);      // span = 3 + 1 - 6 < 0
    run_field(1, 0, 1, 20); run_field(0, 0, 14, 20);
    cur_req = "R6"; setup(4, 6, 5, 1, 4);      // span = 0
    run_field(1, 0, 1, 20); run_field(1, 1, 14, 20);
    cur_req = "R8"; setup(5, 10, 1, 1, 5);
    run_field(1, 1, 1, 12); run_field(1, 1, 10, 12); run_field(0, 0, 10, 8);
    cur_req = "R9"; setup(2, 0, 0, 0, 6);
    run_field(1, 1, 1, 10); run_field(1, 1, 10, 10);
    cur_req = "R1"; setup(257, 256, 1, 2, 2);
    run_field(0, 1, 1, 600); run_field(0, 1, 5, 600); run_field(1, 0, 6, 600);
    cur_req = "R7"; setup(0, 3, 0, 1, 1);
    run_field(1, 1, 1, 6); run_field(0, 1, 4, 6);
    cur_req = "R4"; setup(0, 2, 0, 0, 2);
    run_field(1, 1, 1, 2); run_field(1, 1, 1030, 2);
    cur_req = "R7"; setup(3, 4, 0, 0, 1023);
    run_field(1, 1, 1, 4); run_field(1, 1, 3, 2100);
    tick(); tick();
    checking = 0;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule